// File: doc/BRIEF.md
# Multi-Bank DRAM Read Scheduler with Row-Hit Priority

This block is the back end of a single-channel memory controller. Read requests arrive as a bank, a row and a thread tag, and wait in an eight-entry queue. Each cycle the block chooses at most one request and turns it into the next DRAM command that request needs. A read to a closed bank gets an activate and then a read. A read to a bank that holds another row gets a precharge, an activate and then a read. Per-bank and channel-wide counters enforce the timing rules, so no command is issued early.

One clock cycle is one time unit. Every command holds its bank for 10 cycles. The 64-byte data burst of a read takes the 5 cycles that follow the read's bank-busy window. A read that hits the row left open by the previous read to the same bank may issue 5 cycles after that read. This pipelines row hits back to back on the data bus.

A policy input selects one of two modes. In plain first-come-first-served mode, only the oldest request of each bank may drive that bank. In row-hit-first mode, requests that hit an open row go before older requests, and age breaks ties. When a read's burst has finished, its queue slot is freed and a one-cycle completion pulse carries the slot ID and the thread tag.

Top module: `mc_frfcfs_sched`

## Requirements
- R1: After reset no command and no completion is output, `enq_ready_o` is 1, and every bank is closed: the first command any request causes to a bank is an activate. Command codes on `cmd_type_o` are 0 none, 1 precharge, 2 activate and 3 read.
- R2: A read to a closed bank issues an activate carrying the request's row, then a read to that row exactly 10 cycles later when nothing else contends.
- R3: A read whose bank holds a different open row issues a precharge, then an activate, then a read, each spaced at least 10 cycles apart.
- R4: A read that hits the open row of a bank whose last command was a read may issue 5 cycles after that read.
- R5: Two reads on the channel are never closer than 5 cycles, so data bursts never overlap. A read that is otherwise ready waits for this gap.
- R6: The completion pulse lasts one cycle and comes exactly 15 cycles after the cycle in which its read issued. Its burst occupies cycles +10 to +14. The pulse carries the request's slot ID on `done_id_o` and its thread tag on `done_thr_o`.
- R7: With `policy_i` = 1 (row-hit-first), waiting requests that hit the open row of their bank are served before older requests to that bank, oldest hit first. Across the channel, an eligible hit is chosen over an eligible non-hit command.
- R8: With `policy_i` = 0 (first-come-first-served), only the oldest waiting request of a bank may issue to that bank. The oldest eligible request across banks issues, so a younger request to an idle bank may proceed.
- R9: At most one command issues per cycle. A bank accepts no new command within 10 cycles of its previous one, except the pipelined hit read of R4.
- R10: The queue holds 8 requests. `enq_id_o` shows the lowest free slot, which the next accepted request takes. `enq_ready_o` is 0 while all 8 slots are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per time unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | 0 first-come-first-served, 1 row-hit-first |
| enq_valid_i | input | 1 | New read request present |
| enq_bank_i | input | 2 | Target bank of the request |
| enq_row_i | input | 8 | Target row of the request |
| enq_thr_i | input | 2 | Thread tag of the request |
| enq_ready_o | output | 1 | A queue slot is free |
| enq_id_o | output | 3 | Slot the next accepted request takes |
| cmd_valid_o | output | 1 | A command issues this cycle |
| cmd_type_o | output | 2 | 0 none, 1 precharge, 2 activate, 3 read |
| cmd_bank_o | output | 2 | Bank of the command |
| cmd_row_o | output | 8 | Row of the command (activate and read) |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_id_o | output | 3 | Slot ID of the completed read |
| done_thr_o | output | 2 | Thread tag of the completed read |

## Verification
A stale open-row record shows up at once as an activate to an open bank or a read to the wrong row. The command sequence reveals it in the cycle the command issues. A wrong bank or data-bus counter moves a command one or more cycles off the hand-computed time, so the timestamp check catches it at the first command after the fault. A wrong age order or policy decode reorders the commands of one bank, and the fault appears within the first ten to twenty cycles of the contending requests. A lost countdown shifts or drops a completion pulse, which is seen 15 cycles after the read.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_RD   = 2'd3
  } cmd_e;
endpackage

// File: rtl/mc_bank_state.sv
module mc_bank_state
  import mc_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int T_BANK = 10,
  parameter int T_HIT  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  cmd_e             type_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             idle_o,
  output logic             hit_ok_o
);
  localparam int CW = $clog2(T_BANK + 1);

  logic [CW-1:0] busy_q, hcnt_q;
  logic          last_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o    <= 1'b0;
      row_o     <= '0;
      busy_q    <= '0;
      hcnt_q    <= '0;
      last_rd_q <= 1'b0;
    end else if (issue_i) begin
      busy_q    <= CW'(T_BANK - 1);
      hcnt_q    <= (type_i == CMD_RD) ? CW'(T_HIT - 1) : '0;
      last_rd_q <= (type_i == CMD_RD);
      if (type_i == CMD_PRE) open_o <= 1'b0;
      if (type_i == CMD_ACT) begin
        open_o <= 1'b1;
        row_o  <= row_i;
      end
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (hcnt_q != '0) hcnt_q <= hcnt_q - 1'b1;
    end
  end

  assign idle_o   = (busy_q == '0);
  // a row hit may overlap the tail of the previous read
  assign hit_ok_o = idle_o || (last_rd_q && hcnt_q == '0);
endmodule

// File: rtl/mc_age_pick.sv
module mc_age_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][N-1:0] older_i,  // older_i[j][i]: j arrived before i
  output logic [N-1:0]        gnt_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt_o[i] = req_i[i];
      for (int j = 0; j < N; j++)
        if (req_i[j] && older_i[j][i]) gnt_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mc_frfcfs_sched.sv
module mc_frfcfs_sched
  import mc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 8,
  parameter int THR_W     = 2,
  parameter int T_BANK    = 10,
  parameter int T_HIT     = 5,
  parameter int T_BURST   = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ID_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              policy_i,
  input  logic              enq_valid_i,
  input  logic [BANK_W-1:0] enq_bank_i,
  input  logic [ROW_W-1:0]  enq_row_i,
  input  logic [THR_W-1:0]  enq_thr_i,
  output logic              enq_ready_o,
  output logic [ID_W-1:0]   enq_id_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_type_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              done_valid_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic [THR_W-1:0]  done_thr_o
);
  localparam int DONE_W = $clog2(T_BANK + T_BURST + 1);
  localparam int GAP_W  = $clog2(T_BURST + 1);

  logic [DEPTH-1:0]           q_vld, q_wait;
  logic [BANK_W-1:0]          q_bank [DEPTH];
  logic [ROW_W-1:0]           q_row  [DEPTH];
  logic [THR_W-1:0]           q_thr  [DEPTH];
  logic [DONE_W-1:0]          q_cnt  [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [GAP_W-1:0]           rd_gap_q;

  logic [NUM_BANKS-1:0] b_open, b_idle, b_hok, b_hitany;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];

  logic [DEPTH-1:0] wt, hit, oib, cand, elig, gnt_hit, gnt_all, sel;
  cmd_e             need [DEPTH];
  logic [ID_W-1:0]  sel_idx, free_idx;
  logic             free_any;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mc_bank_state #(.ROW_W(ROW_W), .T_BANK(T_BANK), .T_HIT(T_HIT)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .issue_i (cmd_valid_o && cmd_bank_o == BANK_W'(b)),
      .type_i  (cmd_e'(cmd_type_o)),
      .row_i   (cmd_row_o),
      .open_o  (b_open[b]),
      .row_o   (b_row[b]),
      .idle_o  (b_idle[b]),
      .hit_ok_o(b_hok[b])
    );
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wt[i]  = q_vld[i] && q_wait[i];
      hit[i] = b_open[q_bank[i]] && (b_row[q_bank[i]] == q_row[i]);
    end
    b_hitany = '0;
    for (int i = 0; i < DEPTH; i++)
      if (wt[i] && hit[i]) b_hitany[q_bank[i]] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      oib[i] = wt[i];
      for (int j = 0; j < DEPTH; j++)
        if (wt[j] && q_bank[j] == q_bank[i] && older[j][i]) oib[i] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      // row-hit-first: a bank with waiting hits serves only hits
      cand[i] = (policy_i && b_hitany[q_bank[i]]) ? (wt[i] && hit[i]) : oib[i];
      need[i] = hit[i] ? CMD_RD : (b_open[q_bank[i]] ? CMD_PRE : CMD_ACT);
      elig[i] = cand[i] && ((need[i] == CMD_RD) ? (b_hok[q_bank[i]] && rd_gap_q == '0)
                                                : b_idle[q_bank[i]]);
    end
  end

  mc_age_pick #(.N(DEPTH)) u_pick_hit (.req_i(elig & hit), .older_i(older), .gnt_o(gnt_hit));
  mc_age_pick #(.N(DEPTH)) u_pick_all (.req_i(elig),       .older_i(older), .gnt_o(gnt_all));

  assign sel = (policy_i && |(elig & hit)) ? gnt_hit : gnt_all;

  always_comb begin
    sel_idx  = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) if (sel[i]) sel_idx = ID_W'(i);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!q_vld[i]) begin
        free_idx = ID_W'(i);
        free_any = 1'b1;
      end
  end

  assign cmd_valid_o = |sel;
  assign cmd_type_o  = cmd_valid_o ? need[sel_idx] : CMD_NONE;
  assign cmd_bank_o  = q_bank[sel_idx];
  assign cmd_row_o   = q_row[sel_idx];
  assign enq_ready_o = free_any;
  assign enq_id_o    = free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld        <= '0;
      q_wait       <= '0;
      older        <= '0;
      rd_gap_q     <= '0;
      done_valid_o <= 1'b0;
      done_id_o    <= '0;
      done_thr_o   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_bank[i] <= '0;
        q_row[i]  <= '0;
        q_thr[i]  <= '0;
        q_cnt[i]  <= '0;
      end
    end else begin
      done_valid_o <= 1'b0;
      if (cmd_valid_o && cmd_type_o == CMD_RD) rd_gap_q <= GAP_W'(T_BURST - 1);
      else if (rd_gap_q != '0)                 rd_gap_q <= rd_gap_q - 1'b1;

      for (int i = 0; i < DEPTH; i++) begin
        if (q_vld[i] && !q_wait[i]) begin
          if (q_cnt[i] == DONE_W'(1)) begin
            q_vld[i]     <= 1'b0;
            done_valid_o <= 1'b1;
            done_id_o    <= ID_W'(i);
            done_thr_o   <= q_thr[i];
          end else begin
            q_cnt[i] <= q_cnt[i] - 1'b1;
          end
        end
      end

      if (cmd_valid_o && cmd_type_o == CMD_RD) begin
        q_wait[sel_idx] <= 1'b0;
        q_cnt[sel_idx]  <= DONE_W'(T_BANK + T_BURST - 1);
      end

      if (enq_valid_i && free_any) begin
        q_vld[free_idx]  <= 1'b1;
        q_wait[free_idx] <= 1'b1;
        q_bank[free_idx] <= enq_bank_i;
        q_row[free_idx]  <= enq_row_i;
        q_thr[free_idx]  <= enq_thr_i;
        for (int j = 0; j < DEPTH; j++) begin
          older[free_idx][j] <= 1'b0;
          older[j][free_idx] <= q_vld[j];
        end
      end
    end
  end
endmodule

// File: rtl/mc_frfcfs_sched_chk.sv
module mc_frfcfs_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 8,
  parameter int T_BANK    = 10,
  parameter int T_HIT     = 5,
  parameter int T_BURST   = 5,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_type_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic              done_valid_o,
  input logic              enq_valid_i,
  input logic              enq_ready_o
);
  localparam int LAT   = T_BANK + T_BURST;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [NUM_BANKS-1:0] m_open, m_lrd;
  logic [ROW_W-1:0]     m_row  [NUM_BANKS];
  logic [7:0]           since  [NUM_BANKS];
  logic [7:0]           rd_since;
  logic [LAT-1:0]       rd_hist;
  logic [OCC_W-1:0]     occ;
  logic                 rd_now;

  assign rd_now = cmd_valid_o && cmd_type_o == 2'd3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_open   <= '0;
      m_lrd    <= '0;
      rd_since <= 8'hff;
      rd_hist  <= '0;
      occ      <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        m_row[b] <= '0;
        since[b] <= 8'hff;
      end
    end else begin
      rd_hist  <= {rd_hist[LAT-2:0], rd_now};
      rd_since <= rd_now ? 8'd1 : (rd_since == 8'hff ? rd_since : rd_since + 8'd1);
      occ      <= occ + OCC_W'(enq_valid_i && enq_ready_o) - OCC_W'(done_valid_o);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cmd_valid_o && cmd_bank_o == BANK_W'(b)) begin
          since[b] <= 8'd1;
          m_lrd[b] <= rd_now;
          if (cmd_type_o == 2'd1) m_open[b] <= 1'b0;
          if (cmd_type_o == 2'd2) begin
            m_open[b] <= 1'b1;
            m_row[b]  <= cmd_row_o;
          end
        end else if (since[b] != 8'hff) begin
          since[b] <= since[b] + 8'd1;
        end
      end
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni && cmd_valid_o) begin
      if (cmd_type_o == 2'd2)
        assert_act_closed_R2: assert (!m_open[cmd_bank_o]);
      if (cmd_type_o == 2'd1)
        assert_pre_open_R3: assert (m_open[cmd_bank_o]);
      if (rd_now)
        assert_rd_row_R2: assert (m_open[cmd_bank_o] && m_row[cmd_bank_o] == cmd_row_o);
      assert_bank_spacing_R9: assert (since[cmd_bank_o] >= 8'(T_BANK) ||
          (rd_now && m_lrd[cmd_bank_o] && since[cmd_bank_o] >= 8'(T_HIT)));
      if (rd_now)
        assert_bus_gap_R5: assert (rd_since >= 8'(T_BURST));
    end
  end

  assert_done_timing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o == rd_hist[LAT-1]);

  assert_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_ready_o == !(occ == OCC_W'(DEPTH) && !done_valid_o));
endmodule

bind mc_frfcfs_sched mc_frfcfs_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .ROW_W(ROW_W),
  .T_BANK(T_BANK), .T_HIT(T_HIT), .T_BURST(T_BURST)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_type_o  (cmd_type_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_row_o   (cmd_row_o),
  .done_valid_o(done_valid_o),
  .enq_valid_i (enq_valid_i),
  .enq_ready_o (enq_ready_o)
);

// File: tb/tb_mc_frfcfs_sched.sv
module tb_mc_frfcfs_sched;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] PRE = 2'd1, ACT = 2'd2, RD = 2'd3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       policy_i = 1'b1;
  logic       enq_valid_i = 1'b0;
  logic [1:0] enq_bank_i = '0;
  logic [7:0] enq_row_i = '0;
  logic [1:0] enq_thr_i = '0;
  logic       enq_ready_o, cmd_valid_o, done_valid_o;
  logic [2:0] enq_id_o, done_id_o;
  logic [1:0] cmd_type_o, cmd_bank_o, done_thr_o;
  logic [7:0] cmd_row_o;

  mc_frfcfs_sched dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i),
    .enq_valid_i(enq_valid_i), .enq_bank_i(enq_bank_i), .enq_row_i(enq_row_i),
    .enq_thr_i(enq_thr_i), .enq_ready_o(enq_ready_o), .enq_id_o(enq_id_o),
    .cmd_valid_o(cmd_valid_o), .cmd_type_o(cmd_type_o), .cmd_bank_o(cmd_bank_o),
    .cmd_row_o(cmd_row_o), .done_valid_o(done_valid_o), .done_id_o(done_id_o),
    .done_thr_o(done_thr_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  typedef struct { int t; int ty; int bank; int row; string req; } cmd_exp_t;
  typedef struct { int t; int id; int thr; string req; } done_exp_t;

  cmd_exp_t  cmd_q[$];
  done_exp_t done_q[$];
  int cyc = 0, base = 0, n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic exp_cmd(input int t, input int ty, input int bank, input int row, input string req);
    cmd_exp_t e;
    e.t = base + t; e.ty = ty; e.bank = bank; e.row = row; e.req = req;
    cmd_q.push_back(e);
  endtask

  task automatic exp_done(input int t, input int id, input int thr, input string req);
    done_exp_t e;
    e.t = base + t; e.id = id; e.thr = thr; e.req = req;
    done_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (mon_en && cmd_valid_o) begin
      if (cmd_q.size() == 0) chk(1'b0, "R9", "unexpected command type", int'(cmd_type_o), 0);
      else begin
        cmd_exp_t e;
        e = cmd_q.pop_front();
        chk(cyc == e.t, e.req, "command cycle", cyc - base, e.t - base);
        chk(int'(cmd_type_o) == e.ty, e.req, "command type", int'(cmd_type_o), e.ty);
        chk(int'(cmd_bank_o) == e.bank, e.req, "command bank", int'(cmd_bank_o), e.bank);
        if (e.ty != PRE) chk(int'(cmd_row_o) == e.row, e.req, "command row", int'(cmd_row_o), e.row);
      end
    end
    if (mon_en && done_valid_o) begin
      if (done_q.size() == 0) chk(1'b0, "R6", "unexpected completion id", int'(done_id_o), 0);
      else begin
        done_exp_t e;
        e = done_q.pop_front();
        chk(cyc == e.t, e.req, "completion cycle", cyc - base, e.t - base);
        chk(int'(done_id_o) == e.id, e.req, "completion id", int'(done_id_o), e.id);
        chk(int'(done_thr_o) == e.thr, e.req, "completion thread", int'(done_thr_o), e.thr);
      end
    end
  end

  task automatic do_reset(input bit pol);
    mon_en = 1'b0;
    rst_ni = 1'b0;
    policy_i = pol;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cmd_valid_o, "R1", "cmd_valid after reset", int'(cmd_valid_o), 0);
    chk(!done_valid_o, "R1", "done_valid after reset", int'(done_valid_o), 0);
    chk(enq_ready_o, "R1", "enq_ready after reset", int'(enq_ready_o), 1);
    base = cyc;
  endtask

  task automatic enq(input int bank, input int row, input int thr);
    enq_valid_i = 1'b1;
    enq_bank_i = 2'(bank);
    enq_row_i = 8'(row);
    enq_thr_i = 2'(thr);
    @(negedge clk_i);
    enq_valid_i = 1'b0;
  endtask

  task automatic finish_scn(input int cycles, input string req);
    repeat (cycles) @(negedge clk_i);
    chk(cmd_q.size() == 0, req, "commands still expected", cmd_q.size(), 0);
    chk(done_q.size() == 0, req, "completions still expected", done_q.size(), 0);
    mon_en = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "R9", "watchdog expired at cycle", cyc, 0);
    summary();
  end

  initial begin
    // row-hit-first: hits overtake the older conflicting request (R7, R4, R3)
    do_reset(1'b1);
    exp_cmd(1, ACT, 0, 0, "R1");
    exp_cmd(11, RD, 0, 0, "R2");
    exp_cmd(16, RD, 0, 0, "R4");
    exp_cmd(21, RD, 0, 0, "R7");
    exp_cmd(31, PRE, 0, 0, "R3");
    exp_cmd(41, ACT, 0, 7, "R3");
    exp_cmd(51, RD, 0, 7, "R3");
    exp_done(26, 0, 0, "R6");
    exp_done(31, 2, 0, "R7");
    exp_done(36, 3, 0, "R7");
    exp_done(66, 1, 1, "R6");
    mon_en = 1'b1;
    enq(0, 0, 0); enq(0, 7, 1); enq(0, 0, 0); enq(0, 0, 0);
    finish_scn(80, "R7");

    // same stream in first-come-first-served order (R8, R3, R4)
    do_reset(1'b0);
    exp_cmd(1, ACT, 0, 0, "R2");
    exp_cmd(11, RD, 0, 0, "R2");
    exp_cmd(21, PRE, 0, 0, "R8");
    exp_cmd(31, ACT, 0, 7, "R3");
    exp_cmd(41, RD, 0, 7, "R3");
    exp_cmd(51, PRE, 0, 0, "R8");
    exp_cmd(61, ACT, 0, 0, "R3");
    exp_cmd(71, RD, 0, 0, "R3");
    exp_cmd(76, RD, 0, 0, "R4");
    exp_done(26, 0, 0, "R6");
    exp_done(56, 1, 1, "R8");
    exp_done(86, 2, 0, "R8");
    exp_done(91, 3, 0, "R6");
    mon_en = 1'b1;
    enq(0, 0, 0); enq(0, 7, 1); enq(0, 0, 0); enq(0, 0, 0);
    finish_scn(100, "R8");

    // two banks: parallel activates, reads held apart by the data bus (R5, R9)
    do_reset(1'b1);
    exp_cmd(1, ACT, 0, 1, "R9");
    exp_cmd(2, ACT, 1, 2, "R9");
    exp_cmd(11, RD, 0, 1, "R2");
    exp_cmd(16, RD, 1, 2, "R5");
    exp_done(26, 0, 2, "R6");
    exp_done(31, 1, 3, "R5");
    mon_en = 1'b1;
    enq(0, 1, 2); enq(1, 2, 3);
    finish_scn(40, "R5");

    // first-come-first-served: younger request to another bank proceeds (R8)
    do_reset(1'b0);
    exp_cmd(1, ACT, 2, 3, "R8");
    exp_cmd(3, ACT, 3, 5, "R8");
    exp_cmd(11, RD, 2, 3, "R8");
    exp_cmd(16, RD, 3, 5, "R5");
    exp_cmd(21, PRE, 2, 0, "R8");
    exp_cmd(31, ACT, 2, 4, "R3");
    exp_cmd(41, RD, 2, 4, "R3");
    exp_done(26, 0, 1, "R6");
    exp_done(31, 2, 3, "R8");
    exp_done(56, 1, 2, "R8");
    mon_en = 1'b1;
    enq(2, 3, 1); enq(2, 4, 2); enq(3, 5, 3);
    finish_scn(70, "R8");

    // queue fill: slot IDs, full flag, and drain (R10)
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) begin
      chk(int'(enq_id_o) == i, "R10", "next slot id", int'(enq_id_o), i);
      enq(i % 4, i, i % 4);
    end
    chk(!enq_ready_o, "R10", "ready while full", int'(enq_ready_o), 0);
    begin
      int n_done = 0;
      for (int k = 0; k < 400; k++) begin
        if (done_valid_o) n_done++;
        @(negedge clk_i);
      end
      chk(n_done == 8, "R10", "completions after fill", n_done, 8);
    end
    chk(enq_ready_o, "R10", "ready after drain", int'(enq_ready_o), 1);
    chk(int'(enq_id_o) == 0, "R10", "slot id after drain", int'(enq_id_o), 0);

    summary();
  end
endmodule